// File: doc/BRIEF.md
# Five-Stage Pipelined 16-bit Processor Core

This block is a compact in-order processor with five stages: fetch, decode, execute, memory access and writeback. Between the stages sit five latches: fetch-to-decode, decode-to-execute, execute-to-memory, memory-to-writeback, and a final latch that holds the most recently retired instruction. It executes a seven-instruction 16-bit set: add, nand, load word, store word, branch-if-equal, halt and nop. It has eight 16-bit registers and a single word-addressed memory that holds both the program and its data.

The core has no operand forwarding and no interlock. Software must keep dependent instructions far enough apart, normally by inserting nops. A branch-if-equal is resolved in execute and acted on one stage later. When it is taken, the three younger instructions in flight are discarded. When halt reaches the memory-to-writeback latch, the machine freezes.

The memory is filled through a load port while the core is held in reset. Final state is inspected through combinational debug read ports for the registers and the memory. A cycle counter and a halt flag report progress.

Top module: `pipe16_core`

## Requirements
- R1: While reset is asserted, the PC is 0, every stage latch holds a nop (0xE000) with zero fields, every register reads 0, `cycleCount` is 0 and `halted` is 0.
- R2: The opcode sits in bits 15..13: add=000, nand=001, lw=010, sw=011, beq=100, halt=110, nop=111. Field A is bits 12..10, field B is bits 9..7, and bits 6..0 form a two's-complement offset that is sign-extended to 16 bits. For add and nand, the destination register is bits 6..4.
- R3: add writes A+B, and nand writes ~(A&B), into the destination register. The write happens as the instruction leaves the memory-to-writeback latch.
- R4: lw loads mem[A+offset] into register B. sw stores register B into mem[A+offset] during the memory stage. Only add, nand and lw write a register.
- R5: Register 0 always reads 0; writes to it are discarded.
- R6: Registers are read in decode and there is no forwarding. A consumer fetched at least four slots after its producer (three nops between them) sees the new value. A consumer fetched closer than that sees the old value.
- R7: A beq whose operands are equal loads the PC with its pcPlus1+offset. The fetch, decode and execute latches become nops, so the three instructions after the beq never take effect, even if one of them is a halt. A beq whose operands differ falls through.
- R8: `halted` rises when halt reaches the memory-to-writeback latch. After that, no register, memory word or counter changes. In a straight-line program with halt at address A, `cycleCount` stops at A+4.
- R9: `cycleCount` increments by one on every clock edge after reset until the core halts.
- R10: When `loadEn` is high, `loadData` is written to `loadAddr` at the clock edge. `dbgRegData` and `dbgMemData` show the addressed register and memory word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Memory image write strobe |
| loadAddr | input | AW | Word address for the image write |
| loadData | input | 16 | Image word |
| dbgRegSel | input | 3 | Register index for the debug read |
| dbgRegData | output | 16 | Selected register value |
| dbgMemAddr | input | AW | Word address for the debug read |
| dbgMemData | output | 16 | Selected memory word |
| halted | output | 1 | Halt has reached the memory-to-writeback latch |
| cycleCount | output | CNT_W | Clock edges since reset until halt |

## Verification
The bench builds the core with MEM_WORDS=64 and CNT_W=16. A 64-word memory is enough for a branch target well past the taken branch's discarded delay slots, and for a data area separate from both code paths. A 16-bit counter is wide enough for the exact halt cycle counts: 16 for the straight-line program and 25 for the program with the taken branch. Those counts, together with the final register contents, show the three discarded slots, the stale read of a too-close consumer and the freeze after halt.

// File: rtl/pipe16_pkg.sv
package pipe16_pkg;
  localparam int XLEN = 16;
  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_NAND = 3'b001,
    OP_LW   = 3'b010,
    OP_SW   = 3'b011,
    OP_BEQ  = 3'b100,
    OP_HALT = 3'b110,
    OP_NOP  = 3'b111
  } opcode_t;

  localparam word_t NOP_WORD = 16'hE000;

  typedef struct packed {
    word_t instr;
    word_t pcPlus1;
  } ifid_t;

  typedef struct packed {
    word_t instr;
    word_t pcPlus1;
    word_t opA;
    word_t opB;
    word_t offset;
  } idex_t;

  typedef struct packed {
    word_t instr;
    word_t target;
    word_t aluOut;
    word_t opB;
    logic  equal;
  } exmem_t;

  typedef struct packed {
    word_t instr;
    word_t wData;
  } retire_t;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;
    logic flush;
    logic regWe;
    logic memWe;
  } strobe_t;

  function automatic opcode_t opOf(word_t w);
    return opcode_t'(w[15:13]);
  endfunction
endpackage

// File: rtl/pipe16_regs.sv
module pipe16_regs #(
  parameter int W = 16,
  parameter int NREGS = 8,
  parameter int NRD = 4,
  localparam int RW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          we,
  input  logic [RW-1:0] wAddr,
  input  logic [W-1:0]  wData,
  input  logic [RW-1:0] rdAddr [NRD],
  output logic [W-1:0]  rdData [NRD]
);
  logic [W-1:0] q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : gReg
    if (g == 0) begin : gZero
      assign q[g] = '0;
    end else begin : gFlop
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) r <= '0;
        else if (we && wAddr == RW'(g)) r <= wData;
      end
      assign q[g] = r;
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : gRd
    assign rdData[k] = q[rdAddr[k]];
  end
endmodule

// File: rtl/pipe16_ctrl.sv
module pipe16_ctrl
  import pipe16_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  opcode_t          exMemOp,
  input  logic             exMemEqual,
  input  opcode_t          memWbOp,
  output strobe_t          strobe,
  output logic             halted,
  output logic [CNT_W-1:0] cycleCount
);
  always_comb begin
    halted         = (memWbOp == OP_HALT);
    strobe.advance = !halted;
    strobe.flush   = !halted && exMemOp == OP_BEQ && exMemEqual;
    strobe.regWe   = !halted && (memWbOp inside {OP_ADD, OP_NAND, OP_LW});
    strobe.memWe   = !halted && exMemOp == OP_SW;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cycleCount <= '0;
    else if (strobe.advance) cycleCount <= cycleCount + 1'b1;
  end

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && $stable(cycleCount)));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !halted |=> cycleCount == $past(cycleCount) + CNT_W'(1));
endmodule

// File: rtl/pipe16_dpath.sv
module pipe16_dpath
  import pipe16_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobe,
  input  logic          loadEn,
  input  logic [AW-1:0] loadAddr,
  input  word_t         loadData,
  input  logic [2:0]    dbgRegSel,
  output word_t         dbgRegData,
  input  logic [AW-1:0] dbgMemAddr,
  output word_t         dbgMemData,
  output opcode_t       exMemOp,
  output logic          exMemEqual,
  output opcode_t       memWbOp
);
  localparam ifid_t  IFID_NOP  = '{instr: NOP_WORD, default: '0};
  localparam idex_t  IDEX_NOP  = '{instr: NOP_WORD, default: '0};
  localparam exmem_t EXMEM_NOP = '{instr: NOP_WORD, default: '0};
  localparam retire_t RET_NOP  = '{instr: NOP_WORD, default: '0};

  word_t   pc;
  ifid_t   ifId;
  idex_t   idEx;
  exmem_t  exMem;
  retire_t memWb, wbEnd;

  // unified memory
  word_t mem [MEM_WORDS];
  word_t fetchWord, loadWord;
  assign fetchWord  = mem[pc[AW-1:0]];
  assign loadWord   = mem[exMem.aluOut[AW-1:0]];
  assign dbgMemData = mem[dbgMemAddr];

  always_ff @(posedge clk) begin
    if (loadEn) mem[loadAddr] <= loadData;
    else if (strobe.memWe) mem[exMem.aluOut[AW-1:0]] <= exMem.opB;
  end

  // decode
  word_t sxOff;
  assign sxOff = {{9{ifId.instr[6]}}, ifId.instr[6:0]};

  // writeback destination
  opcode_t wbEndOp;
  logic [2:0] wbDest, cmDest;
  logic cmWrites;
  assign memWbOp = opOf(memWb.instr);
  assign wbEndOp = opOf(wbEnd.instr);
  assign wbDest  = (memWbOp == OP_LW) ? memWb.instr[9:7] : memWb.instr[6:4];
  assign cmDest  = (wbEndOp == OP_LW) ? wbEnd.instr[9:7] : wbEnd.instr[6:4];
  assign cmWrites = wbEndOp inside {OP_ADD, OP_NAND, OP_LW};

  logic [2:0] rdAddr [4];
  word_t      rdData [4];
  assign rdAddr[0] = ifId.instr[12:10];
  assign rdAddr[1] = ifId.instr[9:7];
  assign rdAddr[2] = dbgRegSel;
  assign rdAddr[3] = cmDest;
  assign dbgRegData = rdData[2];

  pipe16_regs #(.W(XLEN), .NREGS(8), .NRD(4)) uRegs (
    .clk(clk), .rstN(rstN),
    .we(strobe.regWe), .wAddr(wbDest), .wData(memWb.wData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  // execute
  opcode_t exOp;
  word_t aluOut;
  logic equal;
  assign exOp = opOf(idEx.instr);
  always_comb begin
    equal = (idEx.opA == idEx.opB);
    case (exOp)
      OP_ADD:       aluOut = idEx.opA + idEx.opB;
      OP_NAND:      aluOut = ~(idEx.opA & idEx.opB);
      OP_LW, OP_SW: aluOut = idEx.opA + idEx.offset;
      default:      aluOut = '0;
    endcase
  end

  // memory stage
  word_t memData;
  assign exMemOp    = opOf(exMem.instr);
  assign exMemEqual = exMem.equal;
  always_comb begin
    case (exMemOp)
      OP_LW:          memData = loadWord;
      OP_ADD, OP_NAND: memData = exMem.aluOut;
      default:        memData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc    <= '0;
      ifId  <= IFID_NOP;
      idEx  <= IDEX_NOP;
      exMem <= EXMEM_NOP;
      memWb <= RET_NOP;
      wbEnd <= RET_NOP;
    end else if (strobe.advance) begin
      memWb <= '{instr: exMem.instr, wData: memData};
      wbEnd <= memWb;
      if (strobe.flush) begin
        pc    <= exMem.target;
        ifId  <= IFID_NOP;
        idEx  <= IDEX_NOP;
        exMem <= EXMEM_NOP;
      end else begin
        pc    <= pc + 16'd1;
        ifId  <= '{instr: fetchWord, pcPlus1: pc + 16'd1};
        idEx  <= '{instr: ifId.instr, pcPlus1: ifId.pcPlus1,
                   opA: rdData[0], opB: rdData[1], offset: sxOff};
        exMem <= '{instr: idEx.instr, target: idEx.pcPlus1 + idEx.offset,
                   aluOut: aluOut, opB: idEx.opB, equal: equal};
      end
    end
  end

  // R7
  squash_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (ifId.instr == NOP_WORD && idEx.instr == NOP_WORD &&
                      exMem.instr == NOP_WORD && pc == $past(exMem.target)));

  // R4
  store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.memWe && !loadEn) |=> mem[$past(exMem.aluOut[AW-1:0])] == $past(exMem.opB));

  // R3
  commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmWrites && cmDest != 3'd0) |-> rdData[3] == wbEnd.wData);
endmodule

// File: rtl/pipe16_core.sv
module pipe16_core #(
  parameter int MEM_WORDS = 64,
  parameter int CNT_W = 32,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [AW-1:0]    loadAddr,
  input  logic [15:0]      loadData,
  input  logic [2:0]       dbgRegSel,
  output logic [15:0]      dbgRegData,
  input  logic [AW-1:0]    dbgMemAddr,
  output logic [15:0]      dbgMemData,
  output logic             halted,
  output logic [CNT_W-1:0] cycleCount
);
  import pipe16_pkg::*;

  strobe_t strobe;
  opcode_t exMemOp, memWbOp;
  logic    exMemEqual;

  pipe16_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .exMemOp(exMemOp), .exMemEqual(exMemEqual), .memWbOp(memWbOp),
    .strobe(strobe), .halted(halted), .cycleCount(cycleCount)
  );

  pipe16_dpath #(.MEM_WORDS(MEM_WORDS)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .dbgRegSel(dbgRegSel), .dbgRegData(dbgRegData),
    .dbgMemAddr(dbgMemAddr), .dbgMemData(dbgMemData),
    .exMemOp(exMemOp), .exMemEqual(exMemEqual), .memWbOp(memWbOp)
  );
endmodule

// File: tb/sim_pipe16_core.sv
`timescale 1ns/1ps
module sim_pipe16_core;
  localparam int MEM_WORDS = 64;
  localparam int CNT_W = 16;
  localparam int AW = $clog2(MEM_WORDS);

  logic clk = 0;
  logic rstN = 0;
  logic loadEn = 0;
  logic [AW-1:0] loadAddr = '0;
  logic [15:0] loadData = '0;
  logic [2:0] dbgRegSel = '0;
  logic [15:0] dbgRegData;
  logic [AW-1:0] dbgMemAddr = '0;
  logic [15:0] dbgMemData;
  logic halted;
  logic [CNT_W-1:0] cycleCount;

  always #2.5 clk = ~clk;

  pipe16_core #(.MEM_WORDS(MEM_WORDS), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .dbgRegSel(dbgRegSel), .dbgRegData(dbgRegData),
    .dbgMemAddr(dbgMemAddr), .dbgMemData(dbgMemData),
    .halted(halted), .cycleCount(cycleCount)
  );

  int checks = 0;
  int fails = 0;

  typedef struct {
    int          kind;   // 0 register, 1 memory
    int          idx;
    logic [15:0] val;
    string       tag;
  } exp_t;
  exp_t expQ[$];
  bit busy = 0;

  logic [15:0] img [MEM_WORDS];

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] enc(int op, int a, int b, int off);
    return {op[2:0], a[2:0], b[2:0], off[6:0]};
  endfunction

  task automatic expectReg(int idx, logic [15:0] v, string tag);
    expQ.push_back('{0, idx, v, tag});
  endtask

  task automatic expectMem(int idx, logic [15:0] v, string tag);
    expQ.push_back('{1, idx, v, tag});
  endtask

  task automatic drain();
    wait (expQ.size() == 0 && !busy);
  endtask

  // monitor: pops expected items and compares debug-port readings
  initial begin
    forever begin
      wait (expQ.size() > 0);
      busy = 1;
      begin
        exp_t e;
        e = expQ.pop_front();
        @(negedge clk);
        if (e.kind == 0) dbgRegSel = e.idx[2:0];
        else dbgMemAddr = e.idx[AW-1:0];
        #1;
        check(e.tag, (e.kind == 0) ? int'(dbgRegData) : int'(dbgMemData), int'(e.val));
      end
      busy = 0;
    end
  end

  task automatic loadImage();
    rstN = 0;
    for (int i = 0; i < MEM_WORDS; i++) begin
      @(negedge clk);
      loadEn = 1; loadAddr = i[AW-1:0]; loadData = img[i];
    end
    @(negedge clk);
    loadEn = 0;
  endtask

  task automatic runToHalt(output bit ok);
    ok = 0;
    @(negedge clk);
    rstN = 1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (halted) begin ok = 1; break; end
    end
    if (!ok) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=%0h expected=%0h", 0, 1);
    end
  endtask

  initial begin
    bit ok;
    // program 1: straight line, padded with nops
    for (int i = 0; i < MEM_WORDS; i++) img[i] = 16'h0000;
    for (int i = 0; i < 16; i++) img[i] = 16'hE000;
    img[0]  = enc(2, 0, 1, 16);      // lw r1 <- mem[r0+16]
    img[4]  = enc(0, 1, 1, 2 << 4);  // add r2 = r1 + r1
    img[8]  = enc(4, 1, 2, -5);      // beq r1 r2 (not equal)
    img[12] = 16'hC000;              // halt
    img[16] = 16'd12345;
    loadImage();

    // reset state
    #1;
    check("R1 halted in reset", int'(halted), 0);
    check("R1 cycleCount in reset", int'(cycleCount), 0);
    for (int r = 0; r < 8; r++) expectReg(r, 16'h0, "R1 register cleared");
    expectMem(16, 16'd12345, "R10 loaded word visible");
    expectMem(8, 16'h857B, "R2/R10 beq encoding loaded");
    drain();

    runToHalt(ok);
    check("R8/R9 halt at 12 stops count", int'(cycleCount), 16);
    expectReg(1, 16'd12345, "R4 lw result");
    expectReg(2, 16'd24690, "R3/R6 add after three nops");
    expectReg(3, 16'h0, "R4 no write by beq");
    expectReg(0, 16'h0, "R5 r0");
    drain();
    repeat (10) @(negedge clk);
    check("R8 count frozen", int'(cycleCount), 16);
    check("R8 halted sticky", int'(halted), 1);

    // program 2: nand, sw, r0 write, stale read, taken branch
    for (int i = 0; i < MEM_WORDS; i++) img[i] = 16'h0000;
    img[0]  = enc(2, 0, 1, 20);      // lw r1
    img[1]  = enc(2, 0, 2, 21);      // lw r2
    img[2]  = 16'hE000; img[3] = 16'hE000; img[4] = 16'hE000;
    img[5]  = enc(1, 1, 2, 3 << 4);  // nand r3
    img[6]  = enc(0, 1, 2, 0);       // add into r0
    img[7]  = enc(0, 1, 1, 4 << 4);  // add r4
    img[8]  = enc(0, 3, 0, 5 << 4);  // add r5 = r3 (stale) + r0
    img[9]  = 16'hE000; img[10] = 16'hE000;
    img[11] = enc(3, 0, 1, 22);      // sw r1 -> mem[22]
    img[12] = enc(4, 0, 0, 17);      // beq taken -> 30
    img[13] = 16'hC000;              // squashed halt
    img[14] = enc(0, 1, 1, 6 << 4);  // squashed add r6
    img[15] = enc(2, 0, 7, 20);      // squashed lw r7
    img[20] = 16'h1234;
    img[21] = 16'h00FF;
    img[30] = enc(0, 1, 2, 6 << 4);  // add r6
    img[31] = 16'hE000; img[32] = 16'hE000; img[33] = 16'hE000;
    img[34] = enc(4, 1, 2, 5);       // beq not taken
    img[35] = 16'hC000;
    loadImage();
    #1;
    check("R1 count cleared by reset", int'(cycleCount), 0);
    check("R1 halted cleared by reset", int'(halted), 0);
    expectReg(2, 16'h0, "R1 registers cleared again");
    drain();

    runToHalt(ok);
    check("R7/R9 branch path halt count", int'(cycleCount), 25);
    expectReg(1, 16'h1234, "R4 lw r1");
    expectReg(2, 16'h00FF, "R4 lw r2");
    expectReg(3, 16'hFFCB, "R3 nand");
    expectReg(4, 16'h2468, "R3 add");
    expectReg(0, 16'h0, "R5 r0 write discarded");
    expectReg(5, 16'h0, "R6 too-close consumer reads old value");
    expectReg(6, 16'h1333, "R7 target executes");
    expectReg(7, 16'h0, "R7 delay slot squashed");
    expectMem(22, 16'h1234, "R4 sw store");
    expectMem(20, 16'h1234, "R4 source word intact");
    drain();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL R8 global watchdog actual=%0h expected=%0h", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule